// File: doc/BRIEF.md
# Next-PC Unit for Mixed 16/32-bit RISC-V Code

This block holds the program counter of an RV32 core whose instruction stream mixes 32-bit base encodings with 16-bit compressed encodings. The core presents the instruction that sits at the current PC. For conditional branches it also presents the two source register values. The unit then computes the address of the next instruction and reports whether control flow is redirected. For the compressed jump-and-link it also supplies the link value for x1.

Three kinds of flow are handled. The first is straight-line advance, where the step size follows from the instruction length. The second is the two equality branches, branch-if-equal and branch-if-not-equal. The third is the compressed jump-and-link. In every redirect the stored immediate counts halfwords: a zero bit is appended below it, the result is sign-extended, and it is added to the address of the redirecting instruction itself. The PC register moves to the computed address only on clock edges where the core raises its advance strobe.

Top module: `next_pc_unit`

## Requirements
- R1: While `rstN` is low, and on the first edge after it rises, `pc` reads 0.
- R2: An instruction whose bits [1:0] are not 2'b11 is compressed. If it is not a jump-and-link, `nextPc` = `pc` + 2 and `taken` = 0.
- R3: An instruction with bits [1:0] = 2'b11 is 32-bit. If its bits [6:0] are not 7'b1100011, `nextPc` = `pc` + 4 and `taken` = 0.
- R4: A 32-bit instruction with bits [6:0] = 7'b1100011 and bits [14:12] = 3'b000 is branch-if-equal. When `rs1Val` equals `rs2Val`, `taken` = 1 and `nextPc` = `pc` + sext({off,1'b0}). The 12-bit field `off` is laid out as off[11]=bit 31, off[10]=bit 7, off[9:4]=bits 30:25 and off[3:0]=bits 11:8.
- R5: A 32-bit instruction with the same opcode and bits [14:12] = 3'b001 is branch-if-not-equal. When the operands differ, `taken` = 1 and `nextPc` follows the R4 formula.
- R6: A branch whose condition fails, or a branch opcode with any other bits [14:12], gives `taken` = 0 and `nextPc` = `pc` + 4.
- R7: A compressed instruction with bits [1:0] = 2'b01 and bits [15:13] = 3'b001 is jump-and-link. It gives `taken` = 1 and `nextPc` = `pc` + sext({j,1'b0}). The 11-bit offset `j` is taken from bits [12:2]: bit 12 feeds j-offset bit 11, bit 11 feeds 4, bits 10:9 feed 9:8, bit 8 feeds 10, bit 7 feeds 6, bit 6 feeds 7, bits 5:3 feed 3:1, and bit 2 feeds 5 (byte-offset bit numbering).
- R8: `linkWe` is high exactly when a jump-and-link is presented with `advance` high. While `linkWe` is high, `linkData` = `pc` + 2.
- R9: On a rising edge with `advance` high, `pc` takes the value `nextPc` had before the edge. With `advance` low, `pc` holds.
- R10: Redirect targets are relative to the redirecting instruction's own address. For example, a jump-and-link at 0x8 with field 2 goes to 0xC, and a branch-if-not-equal at 0xE with field -4 goes to 0x6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | Load `nextPc` into the PC on this edge |
| instr | input | 32 | Instruction at the current PC (compressed forms use bits 15:0) |
| rs1Val | input | XLEN | First branch operand |
| rs2Val | input | XLEN | Second branch operand |
| pc | output | XLEN | Current program counter |
| nextPc | output | XLEN | Address of the following instruction |
| taken | output | 1 | Control flow is redirected |
| linkWe | output | 1 | Write `linkData` to x1 |
| linkData | output | XLEN | Return address of the jump-and-link |

## Verification
A jump-and-link redirects the PC and produces a link value in the same cycle. The bench presents it with the advance strobe high and, before that edge, judges the target, the taken flag, the write enable and `pc`+2 together. It then confirms that the register took the target. Every field value of both immediate forms is swept at a fixed PC and compared against arithmetic on the signed offset. Branches are swept with equal and with unequal operands, so the taken and fall-through paths are each judged on every offset.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [2:0] F3_EQ      = 3'b000;
  localparam logic [2:0] F3_NE      = 3'b001;
  localparam logic [1:0] QUAD_ONE   = 2'b01;
  localparam logic [1:0] LEN_WIDE   = 2'b11;
  localparam logic [2:0] F3_CJUMP   = 3'b001;

  // strobes from decode to the datapath
  typedef struct packed {
    logic compressed;  // 16-bit instruction
    logic jumpLink;    // compressed jump-and-link form
    logic redirect;    // use offset target
    logic loadPc;      // update PC register
    logic linkWe;      // write link value
  } npcCtrlT;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        operandsEqual,
  input  logic        advance,
  output npcCtrlT     ctrl
);
  logic isShort;
  logic isCjal;
  logic isBranch;
  logic condMet;

  always_comb begin
    isShort  = (instr[1:0] != LEN_WIDE);
    isCjal   = isShort && (instr[1:0] == QUAD_ONE) && (instr[15:13] == F3_CJUMP);
    isBranch = !isShort && (instr[6:0] == OPC_BRANCH);
    condMet  = 1'b0;
    if (isBranch) begin
      unique case (instr[14:12])
        F3_EQ:   condMet = operandsEqual;
        F3_NE:   condMet = !operandsEqual;
        default: condMet = 1'b0;
      endcase
    end
  end

  always_comb begin
    ctrl.compressed = isShort;
    ctrl.jumpLink   = isCjal;
    ctrl.redirect   = isCjal || condMet;
    ctrl.loadPc     = advance;
    ctrl.linkWe     = isCjal && advance;
  end
endmodule

// File: rtl/npc_imm.sv
module npc_imm #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output logic [XLEN-1:0] branchOff,
  output logic [XLEN-1:0] jumpOff
);
  localparam int B_W = 13;
  localparam int J_W = 12;

  logic [B_W-1:0] bRaw;
  logic [J_W-1:0] jRaw;

  always_comb begin
    bRaw = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    jRaw = {instr[12], instr[8], instr[10:9], instr[6], instr[7],
            instr[2], instr[11], instr[5:3], 1'b0};
    branchOff = {{(XLEN-B_W){bRaw[B_W-1]}}, bRaw};
    jumpOff   = {{(XLEN-J_W){jRaw[J_W-1]}}, jRaw};
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  npcCtrlT         ctrl,
  output logic            operandsEqual,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkData
);
  localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(2);
  localparam logic [XLEN-1:0] STEP_WIDE  = XLEN'(4);

  logic [XLEN-1:0] pcQ;
  logic [XLEN-1:0] branchOff;
  logic [XLEN-1:0] jumpOff;
  logic [XLEN-1:0] addend;

  npc_imm #(.XLEN(XLEN)) imm_i (
    .instr    (instr),
    .branchOff(branchOff),
    .jumpOff  (jumpOff)
  );

  always_comb begin
    operandsEqual = (rs1Val == rs2Val);
    if (ctrl.redirect)        addend = ctrl.jumpLink ? jumpOff : branchOff;
    else if (ctrl.compressed) addend = STEP_SHORT;
    else                      addend = STEP_WIDE;
    nextPc   = pcQ + addend;
    linkData = pcQ + STEP_SHORT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pcQ <= '0;
    else if (ctrl.loadPc) pcQ <= nextPc;
  end

  assign pc = pcQ;
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            advance,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] nextPc,
  output logic            taken,
  output logic            linkWe,
  output logic [XLEN-1:0] linkData
);
  npcCtrlT ctrl;
  logic    operandsEqual;

  npc_ctrl ctrl_i (
    .instr        (instr),
    .operandsEqual(operandsEqual),
    .advance      (advance),
    .ctrl         (ctrl)
  );

  npc_datapath #(.XLEN(XLEN)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .instr        (instr),
    .rs1Val       (rs1Val),
    .rs2Val       (rs2Val),
    .ctrl         (ctrl),
    .operandsEqual(operandsEqual),
    .pc           (pc),
    .nextPc       (nextPc),
    .linkData     (linkData)
  );

  assign taken  = ctrl.redirect;
  assign linkWe = ctrl.linkWe;
endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            advance,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] nextPc,
  input logic            taken,
  input logic            linkWe,
  input logic [XLEN-1:0] linkData
);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(pc));

  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> pc == $past(nextPc));

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (linkData == pc + XLEN'(2)) && taken && advance);

  // R2
  short_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr[1:0] != 2'b11 && !(instr[1:0] == 2'b01 && instr[15:13] == 3'b001))
      |-> !taken && nextPc == pc + XLEN'(2));

  // R6
  wide_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr[1:0] == 2'b11 && !taken) |-> nextPc == pc + XLEN'(4));

  // R3
  wide_plain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr[1:0] == 2'b11 && instr[6:0] != 7'b1100011) |-> !taken);
endmodule

bind next_pc_unit next_pc_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rstN(rstN), .advance(advance), .instr(instr), .pc(pc),
  .nextPc(nextPc), .taken(taken), .linkWe(linkWe), .linkData(linkData)
);

// File: tb/next_pc_unit_test.sv
module next_pc_unit_test;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            advance = 1'b0;
  logic [31:0]     instr = 32'h0000_0001;
  logic [XLEN-1:0] rs1Val = '0;
  logic [XLEN-1:0] rs2Val = '0;
  logic [XLEN-1:0] pc, nextPc, linkData;
  logic            taken, linkWe;

  int total = 0;
  int fails = 0;
  logic [31:0] expPc = '0;
  bit done = 0;

  next_pc_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rstN(rstN), .advance(advance), .instr(instr),
    .rs1Val(rs1Val), .rs2Val(rs2Val), .pc(pc), .nextPc(nextPc),
    .taken(taken), .linkWe(linkWe), .linkData(linkData)
  );

  always #2 clk = ~clk;

  localparam logic [31:0] C_PLAIN = 32'h0000_0001; // compressed, quadrant 1, not a jump
  localparam logic [31:0] C_MOVE  = 32'h0000_8342; // compressed, quadrant 2
  localparam logic [31:0] W_PLAIN = 32'h00c0_0293; // 32-bit, non-branch opcode

  function automatic logic [31:0] encBr(input logic [2:0] f3, input int field);
    logic [11:0] f;
    f = 12'(field);
    return {f[11], f[9:4], 5'd2, 5'd1, f3, f[3:0], f[10], 7'b1100011};
  endfunction

  function automatic logic [31:0] encJal(input int field);
    logic [11:0] o;
    o = 12'(field * 2);
    return {16'h0, 3'b001, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // present an instruction, judge the combinational result, optionally clock it in
  task automatic present(input logic [31:0] ins, input logic eqOps, input logic adv,
                         input logic [31:0] expNext, input logic expTaken, input string tag);
    logic expLw;
    expLw = adv && (ins[1:0] == 2'b01) && (ins[15:13] == 3'b001);
    if (adv) @(negedge clk);
    instr   = ins;
    rs1Val  = 32'd5;
    rs2Val  = eqOps ? 32'd5 : 32'd6;
    advance = adv;
    #1;
    check({nextPc, taken, linkWe} == {expNext, expTaken, expLw} &&
          (!expLw || linkData == expPc + 32'd2),
          tag, {pc, nextPc, taken, linkWe, 2'b0}, {expPc, expNext, expTaken, expLw, 2'b0});
    if (adv) begin
      @(posedge clk);
      #1;
      advance = 1'b0;
      check(pc == expNext, "R9 load", {36'h0, pc}, {36'h0, expNext});
      expPc = expNext;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : stim
    #1;
    check(pc == 0, "R1 in reset", {36'h0, pc}, 68'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(pc == 0, "R1 after release", {36'h0, pc}, 68'h0);

    // program walk with the stated check vectors
    present(W_PLAIN, 1, 1, 32'h4, 0, "R3 wide step");
    present(C_PLAIN, 1, 1, 32'h6, 0, "R2 short step");
    present(C_PLAIN, 1, 1, 32'h8, 0, "R2 short step");
    present(encJal(2), 1, 1, 32'hC, 1, "R7 R8 R10 jal at 0x8 field 2");
    present(C_MOVE, 1, 1, 32'hE, 0, "R2 quadrant 2 step");
    present(encBr(3'b001, -4), 0, 1, 32'h6, 1, "R5 R10 bne at 0xE field -4");
    present(C_PLAIN, 1, 1, 32'h8, 0, "R2 short step");
    present(encBr(3'b000, 3), 1, 1, 32'hE, 1, "R4 R10 beq at 0x8 field 3");
    present(W_PLAIN, 1, 1, 32'h12, 0, "R3 wide step");
    present(C_PLAIN, 1, 1, 32'h14, 0, "R2 short step");
    present(W_PLAIN, 1, 1, 32'h18, 0, "R3 wide step");
    present(encJal(-6), 1, 1, 32'hC, 1, "R7 R8 R10 jal at 0x18 field -6");
    present(encBr(3'b000, 3), 0, 1, 32'h10, 0, "R6 beq not taken");
    present(encBr(3'b001, 3), 1, 1, 32'h14, 0, "R6 bne not taken");
    present(encBr(3'b100, 3), 0, 1, 32'h18, 0, "R6 other branch kind");

    // hold with advance low
    @(negedge clk); instr = encJal(100); advance = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(pc == expPc && !linkWe, "R9 R8 hold", {35'h0, linkWe, pc}, {36'h0, expPc});

    // full sweeps of both offset fields at the current PC
    for (int k = -1024; k < 1024; k++)
      present(encJal(k), 1, 0, expPc + 32'(k * 2), 1, "R7 sweep");
    for (int k = -2048; k < 2048; k++) begin
      present(encBr(3'b000, k), 1, 0, expPc + 32'(k * 2), 1, "R4 sweep");
      present(encBr(3'b000, k), 0, 0, expPc + 32'd4, 0, "R6 beq sweep");
      present(encBr(3'b001, k), 0, 0, expPc + 32'(k * 2), 1, "R5 sweep");
      present(encBr(3'b001, k), 1, 0, expPc + 32'd4, 0, "R6 bne sweep");
    end

    // most negative jump from the current PC wraps as two's complement
    present(encJal(-1024), 1, 1, expPc - 32'd2048, 1, "R7 R8 far back jal");

    // reset in mid-run
    @(negedge clk); rstN = 1'b0; #1;
    check(pc == 0, "R1 mid-run reset", {36'h0, pc}, 68'h0);
    expPc = 0;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule